// File: doc/BRIEF.md
# Clear-on-Read Interrupt Flag Register

This block keeps the status byte of a timekeeping peripheral's interrupt logic. Three event sources (a periodic tick, an alarm match and the end of a time update) each set their own sticky flag in this byte. Each flag has a matching enable. When any set flag has its enable on, a combined request bit in the byte is 1 and the active-low interrupt output is pulled low. The event sources themselves are outside this block.

Software clears the byte by reading it. A read is one cycle of the read strobe. On the strobe edge the byte is captured into the output register. On the next edge every flag is cleared. Any event that arrives in either of those two cycles is held in a small per-source pending bit and merged into the flags on the clearing edge, so it is not lost. The enables are loaded through a configuration strobe. Reset clears all of them. A rising edge on the set bit clears only the update-ended enable. The byte has no write path from the bus.

Top module: `rtc_irq_status`

## Requirements
- R1: In the status byte, bit 7 is the combined request, bit 6 is the periodic flag, bit 5 is the alarm flag and bit 4 is the update-ended flag. Bits 3 to 0 always read 0.
- R2: An event pulse sets its flag on the next clock edge whatever its enable is. Several flags can be reported together in one read.
- R3: The combined request is 1, and `irq_n` is low, exactly when at least one flag is set while its enable is 1. `irq_n` follows on the edge that sets the flag.
- R4: On the edge where `rd_stb` is 1, `status` takes the current byte and then stays stable until the next read. On the following edge all flags clear, and with no new events `irq_n` returns high.
- R5: An event arriving in the read-strobe cycle or in the clearing cycle after it is missing from that read, and it appears as set in the next read.
- R6: While `rst_n` is low, every flag, pending event, enable and the `status` byte are cleared, and `irq_n` is high.
- R7: When `cfg_wr` is 1, each enable is loaded from its input on that edge. Otherwise the enables hold.
- R8: A rising edge of `set_bit` clears the update-ended enable, even if `cfg_wr` writes it in the same cycle. The periodic and alarm enables are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_periodic | input | 1 | Periodic event pulse |
| evt_alarm | input | 1 | Alarm match event pulse |
| evt_update | input | 1 | Update-ended event pulse |
| cfg_wr | input | 1 | Load strobe for the three enables |
| en_periodic | input | 1 | Periodic enable value to load |
| en_alarm | input | 1 | Alarm enable value to load |
| en_update | input | 1 | Update-ended enable value to load |
| set_bit | input | 1 | Set bit level; its rising edge clears the update enable |
| rd_stb | input | 1 | One-cycle read strobe |
| status | output | 8 | Captured status byte of the last read |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that read strobes are single cycles with at least one idle cycle between them. A back-to-back read would capture the byte before its clearing edge. One assertion states this directly on `rd_stb`. The bench issues every read through one task that holds the strobe for one cycle and then waits out the clearing cycle and one more idle cycle. It drives event pulses and the set bit only on falling edges, each for one cycle, so every rising edge of `set_bit` is a clean 0-to-1 step that the assertions can key on.

// File: rtl/rtc_irq_pkg.sv
// Shared constants for the interrupt status register.
// Assumes source index order update=0, alarm=1, periodic=2,
// which maps onto status bits 4, 5 and 6.
package rtc_irq_pkg;
    localparam int NSRC      = 3;
    localparam int STAT_W    = 8;
    localparam int FLAG_LSB  = 4;
    localparam int REQ_BIT   = STAT_W - 1;

    typedef enum int {
        SRC_UPD = 0,
        SRC_ALM = 1,
        SRC_PER = 2
    } src_e;
endpackage

// File: rtl/rtc_irq_src.sv
// One sticky flag together with its pending-event holder.
// Assumes rd and rd_q are never both 1 (reads are at least two cycles apart).
module rtc_irq_src (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic rd,
    input  logic rd_q,
    output logic flag
);
    logic pend_q;

    // Set the flag on events, defer events during a read, clear and merge afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag   <= 1'b0;
            pend_q <= 1'b0;
        end else if (rd_q) begin
            flag   <= pend_q | evt;
            pend_q <= 1'b0;
        end else if (rd) begin
            pend_q <= pend_q | evt;
        end else begin
            flag   <= flag | evt;
        end
    end
endmodule

// File: rtl/rtc_irq_enables.sv
// Holds the per-source interrupt enables.
// A rising set bit clears the update enable and wins over a load in the same cycle.
module rtc_irq_enables
    import rtc_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [NSRC-1:0] en_in,
    input  logic            set_bit,
    output logic [NSRC-1:0] en_q
);
    logic set_q;
    logic set_rise;

    assign set_rise = set_bit & ~set_q;

    // Remember the previous set bit level so its rising edge can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) set_q <= 1'b0;
        else        set_q <= set_bit;
    end

    // Load the enables on a write; a rising set bit forces the update enable off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            if (cfg_wr) en_q <= en_in;
            if (set_rise) en_q[SRC_UPD] <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_irq_status.sv
// Top of the clear-on-read interrupt status register.
// Captures the byte on the read strobe edge and clears the flags one edge later.
// Assumes read strobes are one cycle long with an idle cycle between them.
module rtc_irq_status
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_periodic,
    input  logic              evt_alarm,
    input  logic              evt_update,
    input  logic              cfg_wr,
    input  logic              en_periodic,
    input  logic              en_alarm,
    input  logic              en_update,
    input  logic              set_bit,
    input  logic              rd_stb,
    output logic [STAT_W-1:0] status,
    output logic              irq_n
);
    logic [NSRC-1:0]   evt_vec;
    logic [NSRC-1:0]   en_vec;
    logic [NSRC-1:0]   en_q;
    logic [NSRC-1:0]   flag_q;
    logic              rd_q;
    logic              req;
    logic [STAT_W-1:0] byte_now;

    assign evt_vec[SRC_UPD] = evt_update;
    assign evt_vec[SRC_ALM] = evt_alarm;
    assign evt_vec[SRC_PER] = evt_periodic;
    assign en_vec[SRC_UPD]  = en_update;
    assign en_vec[SRC_ALM]  = en_alarm;
    assign en_vec[SRC_PER]  = en_periodic;

    genvar gi;
    generate
        for (gi = 0; gi < NSRC; gi++) begin : g_src
            rtc_irq_src u_src (
                .clk   (clk),
                .rst_n (rst_n),
                .evt   (evt_vec[gi]),
                .rd    (rd_stb),
                .rd_q  (rd_q),
                .flag  (flag_q[gi])
            );
        end
    endgenerate

    rtc_irq_enables u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (cfg_wr),
        .en_in   (en_vec),
        .set_bit (set_bit),
        .en_q    (en_q)
    );

    assign req   = |(flag_q & en_q);
    assign irq_n = ~req;

    // Assemble the live status byte from the flags and the request bit.
    always_comb begin
        byte_now          = '0;
        byte_now[REQ_BIT] = req;
        for (int i = 0; i < NSRC; i++) byte_now[FLAG_LSB + i] = flag_q[i];
    end

    // Track the clearing cycle and capture the byte on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            status <= '0;
        end else begin
            rd_q <= rd_stb;
            if (rd_stb) status <= byte_now;
        end
    end
endmodule

// File: rtl/rtc_irq_status_chk.sv
// Property checker for rtc_irq_status, attached by bind.
module rtc_irq_status_chk
    import rtc_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              evt_alarm,
    input logic              set_bit,
    input logic              rd_stb,
    input logic              rd_q,
    input logic [NSRC-1:0]   flag_q,
    input logic [NSRC-1:0]   en_q,
    input logic [STAT_W-1:0] status,
    input logic              irq_n
);
    p_low_nibble_r1: assert property (@(posedge clk) disable iff (!rst_n)
        status[FLAG_LSB-1:0] == '0);

    // R3: the captured request bit equals the inverse of irq_n at read time
    p_req_matches_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> status[REQ_BIT] == !$past(irq_n));

    p_status_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(status));

    // input assumption: reads are spaced by at least one idle cycle
    p_read_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !rd_stb);

    p_defer_merge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q && evt_alarm) |=> flag_q[SRC_ALM]);

    p_reset_clear_r6: assert property (@(posedge clk)
        !rst_n |=> (irq_n && status == '0 && flag_q == '0 && en_q == '0));

    p_set_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $rose(set_bit)) |=> !en_q[SRC_UPD]);
endmodule

bind rtc_irq_status rtc_irq_status_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_alarm (evt_alarm),
    .set_bit   (set_bit),
    .rd_stb    (rd_stb),
    .rd_q      (rd_q),
    .flag_q    (flag_q),
    .en_q      (en_q),
    .status    (status),
    .irq_n     (irq_n)
);

// File: tb/rtc_irq_status_test.sv
module rtc_irq_status_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_periodic = 0, evt_alarm = 0, evt_update = 0;
    logic       cfg_wr = 0, en_periodic = 0, en_alarm = 0, en_update = 0;
    logic       set_bit = 0, rd_stb = 0;
    logic [7:0] status;
    logic       irq_n;
    int         checks = 0;
    int         errors = 0;

    always #10 clk = ~clk;

    rtc_irq_status uut (
        .clk(clk), .rst_n(rst_n),
        .evt_periodic(evt_periodic), .evt_alarm(evt_alarm), .evt_update(evt_update),
        .cfg_wr(cfg_wr), .en_periodic(en_periodic), .en_alarm(en_alarm), .en_update(en_update),
        .set_bit(set_bit), .rd_stb(rd_stb), .status(status), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // mask bit2 periodic, bit1 alarm, bit0 update
    task automatic drive_evt(input logic [2:0] m);
        evt_periodic = m[2]; evt_alarm = m[1]; evt_update = m[0];
    endtask

    task automatic pulse(input logic [2:0] m);
        drive_evt(m);
        @(negedge clk);
        drive_evt(3'b000);
    endtask

    task automatic cfg(input logic [2:0] m);
        cfg_wr = 1; en_periodic = m[2]; en_alarm = m[1]; en_update = m[0];
        @(negedge clk);
        cfg_wr = 0;
    endtask

    // phase 0: events in strobe cycle, 1: in clearing cycle, other: none
    task automatic do_read(input int phase, input logic [2:0] m, output logic [7:0] v);
        rd_stb = 1;
        if (phase == 0) drive_evt(m);
        @(negedge clk);
        rd_stb = 0;
        drive_evt(3'b000);
        v = status;
        if (phase == 1) drive_evt(m);
        @(negedge clk);
        drive_evt(3'b000);
        @(negedge clk);
    endtask

    function automatic logic [7:0] exp_byte(input logic [2:0] f, input logic [2:0] e);
        return {|(f & e), f, 4'b0000};
    endfunction

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        check("R6 reset status", status, 8'h00);
        check("R6 reset irq_n", {7'd0, irq_n}, 8'h01);
        rst_n = 1;
        @(negedge clk);

        // R1 R2 R3 R4 R7: sweep all enable and event combinations
        for (int e = 0; e < 8; e++) begin
            for (int m = 0; m < 8; m++) begin
                cfg(e[2:0]);
                pulse(m[2:0]);
                check("R3 irq_n after events", {7'd0, irq_n}, {7'd0, ~|(m[2:0] & e[2:0])});
                do_read(2, 3'b000, v);
                check("R1 R2 status byte", v, exp_byte(m[2:0], e[2:0]));
                check("R4 irq_n after clear", {7'd0, irq_n}, 8'h01);
                do_read(2, 3'b000, v);
                check("R4 second read empty", v, 8'h00);
            end
        end

        // R5: events during the strobe or clearing cycle are deferred
        cfg(3'b000);
        for (int ph = 0; ph < 2; ph++) begin
            for (int b = 1; b < 8; b++) begin
                logic [2:0] a;
                a = ~b[2:0];
                pulse(a);
                do_read(ph, b[2:0], v);
                check("R5 read during events", v, exp_byte(a, 3'b000));
                do_read(2, 3'b000, v);
                check("R5 deferred events", v, exp_byte(b[2:0], 3'b000));
            end
        end

        // R8: rising set bit clears only the update enable
        cfg(3'b111);
        set_bit = 1;
        @(negedge clk);
        pulse(3'b001);
        check("R8 update masked", {7'd0, irq_n}, 8'h01);
        pulse(3'b010);
        check("R8 alarm still enabled", {7'd0, irq_n}, 8'h00);
        do_read(2, 3'b000, v);
        check("R8 status", v, 8'hB0);
        // R7: load while set held high takes effect
        cfg(3'b001);
        pulse(3'b001);
        check("R7 update enable loaded", {7'd0, irq_n}, 8'h00);
        do_read(2, 3'b000, v);
        set_bit = 0;
        @(negedge clk);
        // R8: rise coinciding with a load still clears the update enable
        set_bit = 1;
        cfg(3'b001);
        pulse(3'b001);
        check("R8 rise beats load", {7'd0, irq_n}, 8'h01);
        do_read(2, 3'b000, v);
        check("R8 flag still recorded", v, 8'h10);
        set_bit = 0;

        // R6: reset mid-run clears flags and enables
        cfg(3'b111);
        pulse(3'b111);
        check("R6 irq before reset", {7'd0, irq_n}, 8'h00);
        rst_n = 0;
        @(negedge clk);
        check("R6 irq released", {7'd0, irq_n}, 8'h01);
        rst_n = 1;
        @(negedge clk);
        do_read(2, 3'b000, v);
        check("R6 flags cleared", v, 8'h00);
        pulse(3'b111);
        check("R6 enables cleared", {7'd0, irq_n}, 8'h01);
        do_read(2, 3'b000, v);
        check("R6 R2 flags without enables", v, 8'h70);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule